// File: doc/BRIEF.md
# Sleep Mode and Wake-up Controller

This block is the power manager of a small microcontroller core. Software picks a sleep depth with a 3-bit mode field and arms sleep with an enable bit. When the CPU then raises its sleep-instruction strobe, the controller enters the chosen sleep state. In that state it drops the clock-domain enables for the CPU, flash, general I/O, converter and asynchronous-timer domains, and the main oscillator enable, following a fixed table for each mode.

While asleep it watches a set of already-enabled interrupt request lines and a reset-request line. Which lines may wake the core depends on the mode. The external interrupt 0 line in the deeper modes, and the asynchronous-timer line, are each qualified by their configuration inputs. Once woken, the controller waits a programmable start-up time, but only after modes that stop the main oscillator. It then holds the CPU for four more cycles with every clock running. Finally it releases the CPU with a one-cycle resume pulse and a flag that says whether to resume after the sleep instruction or to restart at the reset vector.

Top module: `slp_ctrl_top`

## Requirements
- R1: Sleep is entered only from the run state, and only on a clock edge where `sleep_strobe` and `sleep_en` are both 1. A strobe with `sleep_en` at 0, or a strobe in any state other than run, changes nothing.
- R2: The mode codes are 000 idle, 001 converter-quiet, 010 power-down, 011 power-save and 110 standby. A strobe carrying 100, 101 or 111 is ignored and the block stays in run.
- R3: `status` encodes run as 0, sleeping as 1, start-up wait as 2 and halt as 3. The `clk_en` bits are [0] CPU, [1] flash, [2] I/O, [3] converter and [4] async timer. Run and halt give 11111 with `osc_en`=1. While sleeping, idle gives 11100/osc 1, converter-quiet gives 11000/osc 1, power-down gives 00000/osc 0, power-save gives 10000/osc 0 and standby gives 00000/osc 1. During the start-up wait the sleep mask is kept and `osc_en` is 1. `cpu_hold` is 1 in every state except run.
- R4: In idle, any of `irq_ext0`, `irq_pinchg`, `irq_wdt`, `irq_adc`, `irq_periph` or `irq_tmr` wakes the core. `irq_ext0` does so whatever `ext0_level` is.
- R5: In converter-quiet, the wake sources are `irq_ext0` with `ext0_level`=1, `irq_pinchg`, `irq_wdt`, `irq_adc`, and `irq_tmr` with `tmr_async`=1. `irq_periph` does not wake the core.
- R6: In power-down and standby, only `irq_ext0` with `ext0_level`=1, `irq_pinchg` and `irq_wdt` wake the core.
- R7: Power-save has the wake sources of power-down, plus `irq_tmr` when `tmr_async`=1.
- R8: After a wake from power-down or power-save, the block spends N cycles in the start-up wait, where N is `startup_cycles` sampled on the wake edge. After any other mode, or when N=0, it goes straight to halt.
- R9: Halt lasts exactly 4 cycles, with all clock domains and the oscillator enabled and `cpu_hold`=1.
- R10: `resume_pulse` is 1 for exactly the first run cycle after halt. After an interrupt wake, `resume_vec` is 0 there.
- R11: `rst_req` while sleeping wakes the core in every mode and takes priority over interrupts. `rst_req` during the start-up wait or halt also marks the wake as a reset. In both cases `resume_vec` is 1 when the core resumes.
- R12: A synchronous active-high `rst` gives status run, `clk_en`=11111, `osc_en`=1, `cpu_hold`=0, `resume_pulse`=0 and `resume_vec`=0.
- R13: In run, the interrupt inputs and `rst_req` leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Sleep arm bit from the control register |
| sleep_mode | input | 3 | Sleep mode code |
| sleep_strobe | input | 1 | Sleep-instruction strobe from the CPU |
| startup_cycles | input | STW | Oscillator start-up wait in cycles |
| irq_ext0 | input | 1 | External interrupt 0 request (enabled) |
| ext0_level | input | 1 | External interrupt 0 is level-configured |
| irq_pinchg | input | 1 | Pin-change interrupt request |
| irq_wdt | input | 1 | Watchdog interrupt request |
| irq_adc | input | 1 | Converter-complete interrupt request |
| irq_periph | input | 1 | Synchronous peripheral interrupt requests (timers, serial) |
| irq_tmr | input | 1 | Asynchronous-timer interrupt request |
| tmr_async | input | 1 | Asynchronous timer runs from its own clock |
| rst_req | input | 1 | Reset request arriving from a reset source |
| clk_en | output | 5 | Clock-domain enables (CPU, flash, I/O, converter, async timer) |
| osc_en | output | 1 | Main oscillator enable |
| cpu_hold | output | 1 | CPU halted |
| status | output | 2 | Controller state |
| resume_pulse | output | 1 | One-cycle release of the CPU |
| resume_vec | output | 1 | 1: restart at reset vector, 0: resume after sleep |

## Verification
Every output comes from the state, mode and flag registers, so a strobe or wake input that is driven before an edge shows its effect right after that edge. The bench drives inputs on the falling edge and samples one falling edge later. After a wake it expects exactly N samples in start-up wait, then exactly four samples in halt, then the resume pulse on the first run sample and a clear pulse on the next. An input that should be ignored is held for one edge, and the unchanged status and enables are checked on the following falling edge.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_HALT  = 2'd3
  } slp_state_e;

  localparam logic [2:0] MODE_IDLE  = 3'b000;
  localparam logic [2:0] MODE_ADCQ  = 3'b001;
  localparam logic [2:0] MODE_PDOWN = 3'b010;
  localparam logic [2:0] MODE_PSAVE = 3'b011;
  localparam logic [2:0] MODE_STBY  = 3'b110;

  localparam int NDOM      = 5;
  localparam int DOM_CPU   = 0;
  localparam int DOM_FLASH = 1;
  localparam int DOM_IO    = 2;
  localparam int DOM_ADC   = 3;
  localparam int DOM_ASYT  = 4;

  // per-mode wake qualification
  typedef struct packed {
    logic ext0_any;   // external 0 wakes in any trigger configuration
    logic ext0_lvl;   // external 0 wakes only when level-configured
    logic pinchg;
    logic wdt;
    logic adc;
    logic periph;
    logic tmr_any;    // async timer wakes regardless of clock source
    logic tmr_async;  // async timer wakes only in asynchronous clocking
  } wake_mask_t;

  function automatic logic mode_is_valid(input logic [2:0] m);
    return (m == MODE_IDLE) || (m == MODE_ADCQ) || (m == MODE_PDOWN) ||
           (m == MODE_PSAVE) || (m == MODE_STBY);
  endfunction
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [2:0]      mode,
  output logic [NDOM-1:0] dom_mask,
  output logic            osc_on,
  output logic            need_start,
  output wake_mask_t      wmask
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    dom_mask   = '0;
    osc_on     = 1'b1;
    need_start = 1'b0;
    wmask      = '0;
    case (mode)
      MODE_IDLE: begin
        dom_mask[DOM_IO]   = 1'b1;
        dom_mask[DOM_ADC]  = 1'b1;
        dom_mask[DOM_ASYT] = 1'b1;
        wmask.ext0_any     = 1'b1;
        wmask.pinchg       = 1'b1;
        wmask.wdt          = 1'b1;
        wmask.adc          = 1'b1;
        wmask.periph       = 1'b1;
        wmask.tmr_any      = 1'b1;
      end
      MODE_ADCQ: begin
        dom_mask[DOM_ADC]  = 1'b1;
        dom_mask[DOM_ASYT] = 1'b1;
        wmask.ext0_lvl     = 1'b1;
        wmask.pinchg       = 1'b1;
        wmask.wdt          = 1'b1;
        wmask.adc          = 1'b1;
        wmask.tmr_async    = 1'b1;
      end
      MODE_PDOWN: begin
        osc_on         = 1'b0;
        need_start     = 1'b1;
        wmask.ext0_lvl = 1'b1;
        wmask.pinchg   = 1'b1;
        wmask.wdt      = 1'b1;
      end
      MODE_PSAVE: begin
        dom_mask[DOM_ASYT] = 1'b1;
        osc_on             = 1'b0;
        need_start         = 1'b1;
        wmask.ext0_lvl     = 1'b1;
        wmask.pinchg       = 1'b1;
        wmask.wdt          = 1'b1;
        wmask.tmr_async    = 1'b1;
      end
      MODE_STBY: begin
        wmask.ext0_lvl = 1'b1;
        wmask.pinchg   = 1'b1;
        wmask.wdt      = 1'b1;
      end
      default: begin
        // reserved codes are never latched; leave everything gated off
        dom_mask = '0;
      end
    endcase
  end
endmodule

// File: rtl/slp_wake_eval.sv
module slp_wake_eval
  import slp_pkg::*;
(
  input  wake_mask_t wmask,
  input  logic       irq_ext0,
  input  logic       ext0_level,
  input  logic       irq_pinchg,
  input  logic       irq_wdt,
  input  logic       irq_adc,
  input  logic       irq_periph,
  input  logic       irq_tmr,
  input  logic       tmr_async,
  output logic       wake
);
  timeunit 1ns;
  timeprecision 1ps;

  logic ext0_ok, tmr_ok, misc_ok;

  always_comb begin
    ext0_ok = irq_ext0 & (wmask.ext0_any | (wmask.ext0_lvl & ext0_level));
    tmr_ok  = irq_tmr  & (wmask.tmr_any  | (wmask.tmr_async & tmr_async));
    misc_ok = (irq_pinchg & wmask.pinchg) | (irq_wdt & wmask.wdt) |
              (irq_adc & wmask.adc) | (irq_periph & wmask.periph);
    wake    = ext0_ok | tmr_ok | misc_ok;
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int STW      = 8,
  parameter int HALT_CYC = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sleep_en,
  input  logic           sleep_strobe,
  input  logic [2:0]     sleep_mode,
  input  logic [STW-1:0] startup_cycles,
  input  logic           cur_need_start,
  input  logic           wake_irq,
  input  logic           rst_req,
  output slp_state_e     st_q,
  output logic [2:0]     mode_q,
  output logic           vec_q,
  output logic           done_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HW = $clog2(HALT_CYC + 1);
  localparam int CW = (STW > HW) ? STW : HW;
  localparam logic [CW-1:0] HALT_LOAD = CW'(HALT_CYC - 1);

  slp_state_e    st_d;
  logic [2:0]    mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          vec_d, done_d;
  logic          req_ok;

  assign req_ok = sleep_en & sleep_strobe & mode_is_valid(sleep_mode);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    vec_d  = vec_q;
    done_d = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (req_ok) begin
          st_d   = ST_SLEEP;
          mode_d = sleep_mode;
          vec_d  = 1'b0;
        end
      end
      ST_SLEEP: begin
        if (rst_req || wake_irq) begin
          vec_d = rst_req;
          if (cur_need_start && (startup_cycles != '0)) begin
            st_d  = ST_START;
            cnt_d = CW'(startup_cycles - STW'(1));
          end else begin
            st_d  = ST_HALT;
            cnt_d = HALT_LOAD;
          end
        end
      end
      ST_START: begin
        if (rst_req) vec_d = 1'b1;
        if (cnt_q == '0) begin
          st_d  = ST_HALT;
          cnt_d = HALT_LOAD;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_HALT: begin
        if (rst_req) vec_d = 1'b1;
        if (cnt_q == '0) begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      mode_q <= MODE_IDLE;
      cnt_q  <= '0;
      vec_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      vec_q  <= vec_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/slp_ctrl_top.sv
module slp_ctrl_top
  import slp_pkg::*;
#(
  parameter int STW      = 8,
  parameter int HALT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_en,
  input  logic [2:0]      sleep_mode,
  input  logic            sleep_strobe,
  input  logic [STW-1:0]  startup_cycles,
  input  logic            irq_ext0,
  input  logic            ext0_level,
  input  logic            irq_pinchg,
  input  logic            irq_wdt,
  input  logic            irq_adc,
  input  logic            irq_periph,
  input  logic            irq_tmr,
  input  logic            tmr_async,
  input  logic            rst_req,
  output logic [NDOM-1:0] clk_en,
  output logic            osc_en,
  output logic            cpu_hold,
  output logic [1:0]      status,
  output logic            resume_pulse,
  output logic            resume_vec
);
  timeunit 1ns;
  timeprecision 1ps;

  slp_state_e      st_q;
  logic [2:0]      mode_q;
  logic [NDOM-1:0] dom_mask;
  logic            osc_on, need_start, wake_irq;
  wake_mask_t      wmask;

  slp_mode_decode u_dec (
    .mode       (mode_q),
    .dom_mask   (dom_mask),
    .osc_on     (osc_on),
    .need_start (need_start),
    .wmask      (wmask)
  );

  slp_wake_eval u_wake (
    .wmask      (wmask),
    .irq_ext0   (irq_ext0),
    .ext0_level (ext0_level),
    .irq_pinchg (irq_pinchg),
    .irq_wdt    (irq_wdt),
    .irq_adc    (irq_adc),
    .irq_periph (irq_periph),
    .irq_tmr    (irq_tmr),
    .tmr_async  (tmr_async),
    .wake       (wake_irq)
  );

  slp_seq #(.STW(STW), .HALT_CYC(HALT_CYC)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .sleep_en       (sleep_en),
    .sleep_strobe   (sleep_strobe),
    .sleep_mode     (sleep_mode),
    .startup_cycles (startup_cycles),
    .cur_need_start (need_start),
    .wake_irq       (wake_irq),
    .rst_req        (rst_req),
    .st_q           (st_q),
    .mode_q         (mode_q),
    .vec_q          (resume_vec),
    .done_q         (resume_pulse)
  );

  // outputs decode flop state only: no path from any input pin
  always_comb begin
    case (st_q)
      ST_SLEEP: begin
        clk_en = dom_mask;
        osc_en = osc_on;
      end
      ST_START: begin
        clk_en = dom_mask;
        osc_en = 1'b1;
      end
      default: begin
        clk_en = '1;
        osc_en = 1'b1;
      end
    endcase
    cpu_hold = (st_q != ST_RUN);
    status   = st_q;
  end
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
  parameter int HALT_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       sleep_en,
  input logic       sleep_strobe,
  input logic [2:0] sleep_mode,
  input logic       rst_req,
  input logic [1:0] status,
  input logic [4:0] clk_en,
  input logic       osc_en,
  input logic       cpu_hold,
  input logic       resume_pulse,
  input logic       resume_vec
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [7:0] halt_len;
  logic       rsv;

  assign rsv = (sleep_mode == 3'b100) || (sleep_mode == 3'b101) || (sleep_mode == 3'b111);

  always_ff @(posedge clk) begin
    if (rst) halt_len <= '0;
    else if (status == 2'd3) halt_len <= halt_len + 8'd1;
    else halt_len <= '0;
  end

  p_entry_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd1 && $past(status) == 2'd0) |-> $past(sleep_en && sleep_strobe));

  p_reserved_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd0 && sleep_strobe && rsv) |=> status == 2'd0);

  p_run_clocks_r3: assert property (@(posedge clk) disable iff (rst)
    status == 2'd0 |-> (clk_en == 5'b11111 && osc_en && !cpu_hold));

  p_sleep_cpu_off_r3: assert property (@(posedge clk) disable iff (rst)
    status == 2'd1 |-> (!clk_en[0] && !clk_en[1] && cpu_hold));

  p_halt_clocks_r9: assert property (@(posedge clk) disable iff (rst)
    status == 2'd3 |-> (clk_en == 5'b11111 && osc_en && cpu_hold));

  p_halt_len_r9: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd0 && $past(status) == 2'd3) |-> halt_len == 8'(HALT_CYC));

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> (status == 2'd0 && $past(status) == 2'd3));

  p_reset_wake_r11: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd1 && rst_req) |=> (status != 2'd1 && resume_vec));

  p_run_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd0 && !sleep_strobe) |=> status == 2'd0);
endmodule

bind slp_ctrl_top slp_ctrl_chk #(.HALT_CYC(HALT_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_en     (sleep_en),
  .sleep_strobe (sleep_strobe),
  .sleep_mode   (sleep_mode),
  .rst_req      (rst_req),
  .status       (status),
  .clk_en       (clk_en),
  .osc_en       (osc_en),
  .cpu_hold     (cpu_hold),
  .resume_pulse (resume_pulse),
  .resume_vec   (resume_vec)
);

// File: tb/test_slp_ctrl_top.sv
module test_slp_ctrl_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int STW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, sleep_en, sleep_strobe, rst_req;
  logic [2:0] sleep_mode;
  logic [STW-1:0] startup_cycles;
  logic irq_ext0, ext0_level, irq_pinchg, irq_wdt, irq_adc, irq_periph, irq_tmr, tmr_async;
  logic [4:0] clk_en;
  logic osc_en, cpu_hold, resume_pulse, resume_vec;
  logic [1:0] status;

  int nchk = 0;
  int nerr = 0;
  bit done_flag = 0;
  logic [2:0] cur_mode;
  int cur_n;
  bit in_sleep;

  slp_ctrl_top #(.STW(STW), .HALT_CYC(4)) i_slp_ctrl_top (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .sleep_mode(sleep_mode),
    .sleep_strobe(sleep_strobe), .startup_cycles(startup_cycles),
    .irq_ext0(irq_ext0), .ext0_level(ext0_level), .irq_pinchg(irq_pinchg),
    .irq_wdt(irq_wdt), .irq_adc(irq_adc), .irq_periph(irq_periph),
    .irq_tmr(irq_tmr), .tmr_async(tmr_async), .rst_req(rst_req),
    .clk_en(clk_en), .osc_en(osc_en), .cpu_hold(cpu_hold), .status(status),
    .resume_pulse(resume_pulse), .resume_vec(resume_vec)
  );

  function automatic bit mode_ok(input logic [2:0] m);
    return m inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110};
  endfunction

  function automatic int sleep_dom(input logic [2:0] m);
    case (m)
      3'b000: return 5'b11100;
      3'b001: return 5'b11000;
      3'b011: return 5'b10000;
      default: return 0;
    endcase
  endfunction

  function automatic int sleep_osc(input logic [2:0] m);
    return (m == 3'b010 || m == 3'b011) ? 0 : 1;
  endfunction

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'b000: return "R4";
      3'b001: return "R5";
      3'b011: return "R7";
      default: return "R6";
    endcase
  endfunction

  // p: [0] ext0 [1] level cfg [2] pinchg [3] wdt [4] adc [5] periph [6] tmr [7] async
  function automatic bit exp_wake(input logic [2:0] m, input logic [7:0] p);
    bit e_any, e_lvl, t_any, t_as;
    e_any = p[0];
    e_lvl = p[0] & p[1];
    t_any = p[6];
    t_as  = p[6] & p[7];
    case (m)
      3'b000: return e_any | p[2] | p[3] | p[4] | p[5] | t_any;
      3'b001: return e_lvl | p[2] | p[3] | p[4] | t_as;
      3'b011: return e_lvl | p[2] | p[3] | t_as;
      default: return e_lvl | p[2] | p[3];
    endcase
  endfunction

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input string req, input int st, input int dom, input int osc);
    chk_eq(req, "status", int'(status), st);
    chk_eq(req, "clk_en", int'(clk_en), dom);
    chk_eq(req, "osc_en", int'(osc_en), osc);
    chk_eq(req, "cpu_hold", int'(cpu_hold), (st != 0) ? 1 : 0);
  endtask

  task automatic drive(input logic [7:0] p, input logic r);
    irq_ext0 = p[0]; ext0_level = p[1]; irq_pinchg = p[2]; irq_wdt = p[3];
    irq_adc = p[4]; irq_periph = p[5]; irq_tmr = p[6]; tmr_async = p[7];
    rst_req = r;
  endtask

  task automatic enter(input logic [2:0] m, input logic en, input int n);
    sleep_mode = m; sleep_en = en; startup_cycles = STW'(n); sleep_strobe = 1'b1;
    step;
    sleep_strobe = 1'b0; sleep_en = 1'b0;
    in_sleep = en && mode_ok(m);
    if (in_sleep) begin
      cur_mode = m; cur_n = n;
      chk_out("R3", 1, sleep_dom(m), sleep_osc(m));
    end else if (!en) begin
      chk_out("R1", 0, 31, 1);
    end else begin
      chk_out("R2", 0, 31, 1);
    end
  endtask

  // called one sample after the wake edge
  task automatic finish_wake(input bit r, input bit inj_halt);
    int n_eff;
    n_eff = (cur_mode == 3'b010 || cur_mode == 3'b011) ? cur_n : 0;
    for (int i = 0; i < n_eff; i++) begin
      chk_out("R8", 2, sleep_dom(cur_mode), 1);
      step;
    end
    for (int i = 0; i < 4; i++) begin
      chk_out("R9", 3, 31, 1);
      if (inj_halt && i == 1) rst_req = 1'b1;
      step;
      rst_req = 1'b0;
    end
    chk_out("R10", 0, 31, 1);
    chk_eq("R10", "resume_pulse", int'(resume_pulse), 1);
    chk_eq((r || inj_halt) ? "R11" : "R10", "resume_vec", int'(resume_vec), (r || inj_halt) ? 1 : 0);
    step;
    chk_eq("R10", "resume_pulse after", int'(resume_pulse), 0);
    in_sleep = 0;
  endtask

  task automatic try_wake(input logic [7:0] p, input bit r, input bit inj_halt, output bit woke);
    drive(p, r);
    step;
    drive(8'h00, 1'b0);
    woke = r || exp_wake(cur_mode, p);
    if (woke) finish_wake(r, inj_halt);
    else chk_out(mode_req(cur_mode), 1, sleep_dom(cur_mode), sleep_osc(cur_mode));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit w;
    void'($urandom(32'd20240611));
    rst = 1'b1; sleep_en = 0; sleep_strobe = 0; sleep_mode = 3'b000;
    startup_cycles = '0; in_sleep = 0; cur_mode = 3'b000; cur_n = 0;
    drive(8'h00, 1'b0);
    @(negedge clk);
    repeat (3) step;
    rst = 1'b0;
    step;
    // R12 reset state
    chk_out("R12", 0, 31, 1);
    chk_eq("R12", "resume_pulse", int'(resume_pulse), 0);
    chk_eq("R12", "resume_vec", int'(resume_vec), 0);

    // R1 strobe without enable
    enter(3'b010, 1'b0, 3);
    // R2 reserved codes
    enter(3'b100, 1'b1, 0);
    enter(3'b101, 1'b1, 0);
    enter(3'b111, 1'b1, 0);

    // R13 run ignores interrupts and reset requests
    drive(8'hFF, 1'b1);
    step;
    drive(8'h00, 1'b0);
    chk_out("R13", 0, 31, 1);
    chk_eq("R13", "resume_vec", int'(resume_vec), 0);

    // Idle, strobe while asleep ignored, edge-configured ext0 wakes
    enter(3'b000, 1'b1, 7);
    sleep_mode = 3'b010; sleep_en = 1'b1; sleep_strobe = 1'b1;
    step;
    sleep_strobe = 1'b0; sleep_en = 1'b0;
    chk_out("R1", 1, 5'b11100, 1);
    try_wake(8'b0000_0001, 1'b0, 1'b0, w);
    chk_eq("R4", "woke", int'(w), 1);

    // Power-down: edge ext0 and async timer ignored, watchdog wakes after start-up
    enter(3'b010, 1'b1, 3);
    try_wake(8'b0000_0001, 1'b0, 1'b0, w);
    try_wake(8'b1100_0000, 1'b0, 1'b0, w);
    try_wake(8'b0011_0000, 1'b0, 1'b0, w);
    try_wake(8'b0000_1000, 1'b0, 1'b0, w);
    chk_eq("R6", "woke", int'(w), 1);

    // Power-save: synchronous timer ignored, async timer wakes
    enter(3'b011, 1'b1, 2);
    try_wake(8'b0100_0000, 1'b0, 1'b0, w);
    try_wake(8'b1100_0000, 1'b0, 1'b0, w);
    chk_eq("R7", "woke", int'(w), 1);

    // Converter-quiet: peripheral ignored, converter wakes, no start-up
    enter(3'b001, 1'b1, 5);
    try_wake(8'b0010_0000, 1'b0, 1'b0, w);
    try_wake(8'b0001_0000, 1'b0, 1'b0, w);
    chk_eq("R5", "woke", int'(w), 1);

    // Standby: level ext0 wakes, no start-up
    enter(3'b110, 1'b1, 4);
    try_wake(8'b0000_0011, 1'b0, 1'b0, w);
    chk_eq("R8", "woke", int'(w), 1);

    // Reset request while asleep together with an interrupt
    enter(3'b010, 1'b1, 2);
    try_wake(8'b0000_0100, 1'b1, 1'b0, w);
    // Reset request during halt after an interrupt wake
    enter(3'b010, 1'b1, 2);
    try_wake(8'b0000_0100, 1'b0, 1'b1, w);
    // Zero start-up in power-down
    enter(3'b010, 1'b1, 0);
    try_wake(8'b0000_0100, 1'b0, 1'b0, w);

    // constrained random
    for (int it = 0; it < 80; it++) begin
      logic [2:0] m;
      logic en;
      int n;
      logic [7:0] p;
      m  = 3'($urandom % 8);
      en = (($urandom % 4) != 0);
      n  = int'($urandom % 6);
      if (($urandom % 3) == 0) begin
        p = 8'($urandom);
        drive(p, 1'($urandom % 2));
        step;
        drive(8'h00, 1'b0);
        chk_out("R13", 0, 31, 1);
      end
      enter(m, en, n);
      if (in_sleep) begin
        w = 0;
        for (int k = 0; k < 4 && !w; k++) begin
          p = '0;
          for (int b = 0; b < 8; b++) p[b] = (($urandom % 10) < 2);
          try_wake(p, (($urandom % 12) == 0), 1'b0, w);
        end
        if (!w) try_wake(8'b0000_0100, 1'b0, 1'b0, w);
      end
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule